// File: doc/BRIEF.md
# Fluorescent Display Grid Scanner with Key Matrix Scan

This block times a grid-multiplexed vacuum fluorescent display. It walks through a configurable number of display time slots. In each slot it turns on one grid line and drives the segment lines with a row pattern fetched from display memory. Every slot is divided into sixteen equal steps. A brightness setting picks how many of the final steps are lit, and the steps before them stay blank.

Sixteen of the outputs are dual-purpose. A per-output select makes each of them either a grid line or a segment line. The other outputs are segment lines only. When key scanning is enabled, one extra slot follows the last display slot. In that slot the grids are dark and the first sixteen segment-only lines are pulsed one at a time as key strobes. Eight return inputs are captured into a sixteen-byte key buffer. A sticky flag reports when any captured byte differs from the byte it replaces.

Display memory is reached through a plain read port with a registered output. The block presents a byte address and uses the returned row one cycle later.

Top module: `vfd_grid_scanner`

## Requirements
- R1: After reset all display outputs, every key buffer byte and the change flag are 0. While `en` is low the counters are held at the first step of slot 0, and all display outputs read 0 starting from the cycle after `en` was sampled low.
- R2: The effective display slot count is `slotCount`, with 0 treated as 1 and any value above 20 treated as 20. One frame holds that many display slots plus one key slot when `keyScanEn` is 1. Each slot lasts 16 steps of `TICKS` cycles, and after the last slot the frame starts again at slot 0.
- R3: A dual output `i` with `gridSel[i]=1` is high only during the lit steps of display slot `i`. At most one such grid output is high at a time.
- R4: In display slot `n` the block presents `ramAddr = ramBase + n*ROW_BYTES` (the sum wraps at the address width). During lit steps, row bit `i` drives dual output `i` when `gridSel[i]=0`, and row bit `DUAL+k` drives `segOut[k]`. Outputs are registered: the value seen in a cycle reflects the counter state of the previous cycle and the memory data returned for the address of the cycle before that.
- R5: Step `s` (0 to 15) of a display slot is lit when `s + dimLevel >= 16`. With `dimLevel=0` every display slot stays dark, and with `dimLevel=15` steps 1 to 15 are lit.
- R6: In the key slot all dual outputs are 0. During step `j`, `segOut[j]` alone is 1 among `segOut[15:0]`, and every higher segment-only output is 0.
- R7: In the key slot, the return inputs are stored into key byte `j` on the last cycle in which strobe `j` is visible at the outputs. Byte `j` can be read on `keyRdData` by setting `keyRdIdx=j`. When key scanning is off, the buffer keeps its contents.
- R8: `keyChanged` is set when a stored key byte differs from its previous value. It stays set until a `keyChgClr` pulse, and a difference detected in the same cycle as the pulse takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| en | input | 1 | Scan enable; low holds the counters and blanks the outputs |
| slotCount | input | 5 | Number of display slots, clamped to 1..20 |
| dimLevel | input | 4 | Number of lit sixteenths at the end of each display slot |
| gridSel | input | DUAL | Per dual output: 1 selects grid, 0 selects segment |
| keyScanEn | input | 1 | Adds the key scan slot to each frame |
| ramBase | input | ADDR_W | Display memory byte address of the row for slot 0 |
| ramAddr | output | ADDR_W | Display memory read address |
| ramData | input | DUAL+SEG_ONLY | Row returned one cycle after the address |
| dualOut | output | DUAL | Dual-purpose grid/segment outputs |
| segOut | output | SEG_ONLY | Segment-only outputs; the first 16 also serve as key strobes |
| keyIn | input | 8 | Key matrix return lines |
| keyRdIdx | input | 4 | Key buffer byte select |
| keyRdData | output | 8 | Selected key buffer byte |
| keyChgClr | input | 1 | Clears the key change flag |
| keyChanged | output | 1 | Sticky key change flag |

## Verification
The bench builds the block with `TICKS=2`, 16 dual and 16 segment-only outputs, and an 8-bit address, which gives 4-byte rows. Two cycles per step place the key capture point on the second tick of each strobe step. A full 20-slot frame with the key slot then lasts only 672 cycles, so the clamp limits, address wrap past the top of memory, both dimmer extremes and repeated key scans with unchanged and changed matrices all fit in a short run. A memory model and a key matrix model in the bench feed the block, and every output cycle is compared against an expected value worked out from the slot and step position.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;
  localparam int MAX_SLOTS = 20;
  localparam int STEPS     = 16;
  localparam int SLOT_W    = 5;
  localparam int STEP_W    = 4;
  localparam int KEY_W     = 8;

  typedef struct packed {
    logic                dispSlot;  // current slot shows display data
    logic                keySlot;   // current slot is the key scan slot
    logic                active;    // lit portion of a display slot
    logic                keySample; // last tick of a strobe step
    logic [SLOT_W-1:0]   slot;
    logic [STEP_W-1:0]   step;
  } scanStrobe_t;
endpackage

// File: rtl/vfd_scan_ctrl.sv
module vfd_scan_ctrl
  import vfd_scan_pkg::*;
#(
  parameter int TICKS     = 4,
  parameter int ADDR_W    = 12,
  parameter int ROW_BYTES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                en,
  input  logic [SLOT_W-1:0]   slotCount,
  input  logic [STEP_W-1:0]   dimLevel,
  input  logic                keyScanEn,
  input  logic [ADDR_W-1:0]   ramBase,
  output scanStrobe_t         strb,
  output logic [ADDR_W-1:0]   ramAddr
);
  localparam int TICK_W = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [TICK_W-1:0] tick;
  logic [STEP_W-1:0] step;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] nSlots;
  logic [SLOT_W-1:0] lastSlot;
  logic              tickLast;
  logic              stepLast;

  always_comb begin
    if (slotCount == '0)                          nSlots = SLOT_W'(1);
    else if (slotCount > SLOT_W'(MAX_SLOTS))      nSlots = SLOT_W'(MAX_SLOTS);
    else                                          nSlots = slotCount;
    lastSlot = keyScanEn ? nSlots : nSlots - SLOT_W'(1);
  end

  assign tickLast = (tick == TICK_W'(TICKS - 1));
  assign stepLast = (step == STEP_W'(STEPS - 1));

  // tick -> step -> slot counter chain
  always_ff @(posedge clk) begin
    if (!rstN || !en) begin
      tick <= '0;
      step <= '0;
      slot <= '0;
    end else if (tickLast) begin
      tick <= '0;
      if (stepLast) begin
        step <= '0;
        slot <= (slot >= lastSlot) ? '0 : slot + SLOT_W'(1);
      end else begin
        step <= step + STEP_W'(1);
      end
    end else begin
      tick <= tick + TICK_W'(1);
    end
  end

  always_comb begin
    strb.slot      = slot;
    strb.step      = step;
    strb.dispSlot  = en && (slot < nSlots);
    strb.keySlot   = en && keyScanEn && (slot == nSlots);
    strb.active    = strb.dispSlot &&
                     (({1'b0, step} + {1'b0, dimLevel}) >= (STEP_W + 1)'(STEPS));
    strb.keySample = strb.keySlot && tickLast;
  end

  assign ramAddr = ramBase + ADDR_W'(int'(slot) * ROW_BYTES);
endmodule

// File: rtl/vfd_scan_datapath.sv
module vfd_scan_datapath
  import vfd_scan_pkg::*;
#(
  parameter int DUAL     = 16,
  parameter int SEG_ONLY = 40
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  scanStrobe_t              strb,
  input  logic [DUAL-1:0]          gridSel,
  input  logic [DUAL+SEG_ONLY-1:0] ramData,
  input  logic [KEY_W-1:0]         keyIn,
  input  logic [STEP_W-1:0]        keyRdIdx,
  input  logic                     keyChgClr,
  output logic [DUAL-1:0]          dualOut,
  output logic [SEG_ONLY-1:0]      segOut,
  output logic [KEY_W-1:0]         keyRdData,
  output logic                     keyChanged
);
  logic [DUAL-1:0]     dualNext;
  logic [SEG_ONLY-1:0] segNext;

  for (genvar i = 0; i < DUAL; i++) begin : g_dual
    always_comb begin
      if (gridSel[i]) dualNext[i] = strb.active && (strb.slot == SLOT_W'(i));
      else            dualNext[i] = strb.active && ramData[i];
    end
  end

  for (genvar k = 0; k < SEG_ONLY; k++) begin : g_seg
    if (k < STEPS) begin : g_strobe
      assign segNext[k] = strb.active ? ramData[DUAL+k]
                                      : (strb.keySlot && (strb.step == STEP_W'(k)));
    end else begin : g_plain
      assign segNext[k] = strb.active && ramData[DUAL+k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dualOut <= '0;
      segOut  <= '0;
    end else begin
      dualOut <= dualNext;
      segOut  <= segNext;
    end
  end

  // key capture, delayed one cycle to line up with the registered strobe
  logic [KEY_W-1:0]  keyBuf [STEPS];
  logic              sampleD;
  logic [STEP_W-1:0] idxD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleD    <= 1'b0;
      idxD       <= '0;
      keyChanged <= 1'b0;
      for (int j = 0; j < STEPS; j++) keyBuf[j] <= '0;
    end else begin
      sampleD <= strb.keySample;
      idxD    <= strb.step;
      if (sampleD) keyBuf[idxD] <= keyIn;
      if (sampleD && (keyIn != keyBuf[idxD])) keyChanged <= 1'b1;
      else if (keyChgClr)                     keyChanged <= 1'b0;
    end
  end

  assign keyRdData = keyBuf[keyRdIdx];
endmodule

// File: rtl/vfd_grid_scanner.sv
module vfd_grid_scanner
  import vfd_scan_pkg::*;
#(
  parameter int DUAL     = 16,
  parameter int SEG_ONLY = 40,
  parameter int TICKS    = 4,
  parameter int ADDR_W   = 12,
  localparam int ROW_W     = DUAL + SEG_ONLY,
  localparam int ROW_BYTES = (ROW_W + 7) / 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 en,
  input  logic [4:0]           slotCount,
  input  logic [3:0]           dimLevel,
  input  logic [DUAL-1:0]      gridSel,
  input  logic                 keyScanEn,
  input  logic [ADDR_W-1:0]    ramBase,
  output logic [ADDR_W-1:0]    ramAddr,
  input  logic [ROW_W-1:0]     ramData,
  output logic [DUAL-1:0]      dualOut,
  output logic [SEG_ONLY-1:0]  segOut,
  input  logic [7:0]           keyIn,
  input  logic [3:0]           keyRdIdx,
  output logic [7:0]           keyRdData,
  input  logic                 keyChgClr,
  output logic                 keyChanged
);
  scanStrobe_t strb;

  vfd_scan_ctrl #(.TICKS(TICKS), .ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .en(en), .slotCount(slotCount), .dimLevel(dimLevel),
    .keyScanEn(keyScanEn), .ramBase(ramBase), .strb(strb), .ramAddr(ramAddr)
  );

  vfd_scan_datapath #(.DUAL(DUAL), .SEG_ONLY(SEG_ONLY)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .gridSel(gridSel), .ramData(ramData),
    .keyIn(keyIn), .keyRdIdx(keyRdIdx), .keyChgClr(keyChgClr),
    .dualOut(dualOut), .segOut(segOut), .keyRdData(keyRdData), .keyChanged(keyChanged)
  );
endmodule

// File: rtl/vfd_grid_scanner_chk.sv
module vfd_grid_scanner_chk #(
  parameter int DUAL     = 16,
  parameter int SEG_ONLY = 40
) (
  input logic                clk,
  input logic                rstN,
  input logic                en,
  input logic [3:0]          dimLevel,
  input logic [DUAL-1:0]     gridSel,
  input logic                keyScanEn,
  input logic [DUAL-1:0]     dualOut,
  input logic [SEG_ONLY-1:0] segOut,
  input logic                keyChgClr,
  input logic                keyChanged
);
  // R1: a disabled cycle blanks every display output on the next cycle
  assert_idle_dark_R1: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (dualOut == '0 && segOut == '0));

  // R3: never more than one grid line lit
  assert_single_grid_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dualOut & $past(gridSel)));

  // R5: dimmer at zero with no key slot leaves the panel dark
  assert_dim_zero_dark_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dimLevel == 4'd0 && !keyScanEn) |=> (dualOut == '0 && segOut == '0));

  // R8: change flag holds until cleared
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (keyChanged && !keyChgClr) |=> keyChanged);
endmodule

bind vfd_grid_scanner vfd_grid_scanner_chk #(.DUAL(DUAL), .SEG_ONLY(SEG_ONLY)) chk_i (
  .clk(clk), .rstN(rstN), .en(en), .dimLevel(dimLevel), .gridSel(gridSel),
  .keyScanEn(keyScanEn), .dualOut(dualOut), .segOut(segOut),
  .keyChgClr(keyChgClr), .keyChanged(keyChanged)
);

// File: tb/vfd_grid_scanner_tb.sv
module vfd_grid_scanner_tb_top;
  localparam int DUAL = 16;
  localparam int SEG_ONLY = 16;
  localparam int TICKS = 2;
  localparam int ADDR_W = 8;
  localparam int ROW_W = DUAL + SEG_ONLY;
  localparam int ROW_BYTES = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic en = 1'b0;
  logic [4:0] slotCount = 5'd1;
  logic [3:0] dimLevel = 4'd0;
  logic [DUAL-1:0] gridSel = '0;
  logic keyScanEn = 1'b0;
  logic [ADDR_W-1:0] ramBase = '0;
  logic [ADDR_W-1:0] ramAddr;
  logic [ROW_W-1:0] ramData = '0;
  logic [DUAL-1:0] dualOut;
  logic [SEG_ONLY-1:0] segOut;
  logic [7:0] keyIn;
  logic [3:0] keyRdIdx = '0;
  logic [7:0] keyRdData;
  logic keyChgClr = 1'b0;
  logic keyChanged;

  int total = 0;
  int bad = 0;

  logic [ROW_W-1:0] mem [256];
  logic [7:0] keyMat [16];
  logic [7:0] expBuf [16];

  always #2 clk = ~clk;

  vfd_grid_scanner #(.DUAL(DUAL), .SEG_ONLY(SEG_ONLY), .TICKS(TICKS), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .en(en), .slotCount(slotCount), .dimLevel(dimLevel),
    .gridSel(gridSel), .keyScanEn(keyScanEn), .ramBase(ramBase), .ramAddr(ramAddr),
    .ramData(ramData), .dualOut(dualOut), .segOut(segOut), .keyIn(keyIn),
    .keyRdIdx(keyRdIdx), .keyRdData(keyRdData), .keyChgClr(keyChgClr), .keyChanged(keyChanged)
  );

  // memory model with registered read
  always @(posedge clk) ramData <= mem[ramAddr];

  // key matrix model: a return line is pulled by every pressed key on a live strobe
  always_comb begin
    keyIn = '0;
    for (int j = 0; j < 16; j++) if (segOut[j]) keyIn = keyIn | keyMat[j];
  end

  function automatic int effSlots(input logic [4:0] sc);
    if (sc == 0) return 1;
    if (sc > 20) return 20;
    return int'(sc);
  endfunction

  // expected {segOut, dualOut} for counter state c since enable
  function automatic logic [31:0] expOut(input int c);
    int n, tot, fl, pos, slot, step;
    logic [ROW_W-1:0] row;
    logic act;
    logic [15:0] d, s;
    n = effSlots(slotCount);
    tot = n + (keyScanEn ? 1 : 0);
    fl = tot * 16 * TICKS;
    pos = c % fl;
    slot = pos / (16 * TICKS);
    step = (pos % (16 * TICKS)) / TICKS;
    d = '0; s = '0;
    if (slot < n) begin
      row = mem[(int'(ramBase) + slot * ROW_BYTES) % 256];
      act = (step + int'(dimLevel)) >= 16;
      for (int i = 0; i < 16; i++)
        d[i] = gridSel[i] ? (act && slot == i) : (act && row[i]);
      s = act ? row[31:16] : 16'h0;
    end else begin
      s = 16'h1 << step;
    end
    return {s, d};
  endfunction

  function automatic string tagFor(input int c);
    int n, pos, slot;
    n = effSlots(slotCount);
    pos = c % ((n + (keyScanEn ? 1 : 0)) * 16 * TICKS);
    slot = pos / (16 * TICKS);
    if (slot >= n) return "R6";
    if (dimLevel == 0) return "R5";
    return "R4";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runCfg(input logic [4:0] sc, input logic [3:0] dim, input logic [15:0] gs,
                        input logic kEn, input logic [7:0] base, input int frames,
                        input bit newMat);
    int fl, cycles, gridHi;
    logic [31:0] e;
    logic anyDiff;
    @(negedge clk);
    en = 1'b0; slotCount = sc; dimLevel = dim; gridSel = gs; keyScanEn = kEn; ramBase = base;
    keyChgClr = 1'b1;
    if (newMat) for (int j = 0; j < 16; j++) keyMat[j] = 8'($urandom);
    @(negedge clk);
    keyChgClr = 1'b0;
    check("R8", {31'd0, keyChanged}, 32'd0);
    en = 1'b1;
    fl = (effSlots(sc) + (kEn ? 1 : 0)) * 16 * TICKS;
    cycles = fl * frames;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      e = expOut(c);
      check(tagFor(c), {segOut, dualOut}, e);
      gridHi = $countones(dualOut & gridSel);
      if (gridHi > 1) check("R3", 32'(gridHi), 32'd1);
    end
    @(negedge clk);
    // frame length: the state after a whole number of frames is slot 0, step 0
    check("R2", {segOut, dualOut}, expOut(0));
    en = 1'b0;
    @(negedge clk);
    check("R1", {segOut, dualOut}, 32'd0);
    anyDiff = 1'b0;
    if (kEn) for (int j = 0; j < 16; j++) begin
      if (keyMat[j] != expBuf[j]) anyDiff = 1'b1;
      expBuf[j] = keyMat[j];
    end
    for (int j = 0; j < 16; j++) begin
      keyRdIdx = 4'(j);
      #1;
      check("R7", {24'd0, keyRdData}, {24'd0, expBuf[j]});
    end
    check("R8", {31'd0, keyChanged}, {31'd0, anyDiff});
  endtask

  initial begin
    #600000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int a = 0; a < 256; a++) mem[a] = $urandom;
    for (int j = 0; j < 16; j++) begin keyMat[j] = '0; expBuf[j] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {segOut, dualOut}, 32'd0);
    check("R1", {31'd0, keyChanged}, 32'd0);
    for (int j = 0; j < 16; j++) begin
      keyRdIdx = 4'(j);
      #1;
      check("R1", {24'd0, keyRdData}, 32'd0);
    end
    // directed corners
    runCfg(5'd0,  4'd15, 16'hFFFF, 1'b0, 8'h10, 3, 1'b1); // R2 zero count -> 1 slot
    runCfg(5'd25, 4'd8,  16'h00FF, 1'b1, 8'hF0, 2, 1'b1); // R2 clamp to 20, R4 address wrap
    runCfg(5'd20, 4'd8,  16'h00FF, 1'b1, 8'hF0, 1, 1'b0); // R8 same matrix, no change
    runCfg(5'd4,  4'd0,  16'h000F, 1'b0, 8'h00, 2, 1'b1); // R5 dark, R7 buffer kept
    runCfg(5'd16, 4'd15, 16'h0000, 1'b1, 8'h20, 2, 1'b1); // R4 all dual as segments
    runCfg(5'd16, 4'd1,  16'hFFFF, 1'b1, 8'h44, 2, 1'b1); // R3 all grids, one lit step
    // random configurations
    for (int r = 0; r < 6; r++)
      runCfg(5'($urandom_range(0, 22)), 4'($urandom), 16'($urandom), 1'($urandom),
             8'($urandom), 2, 1'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule